// File: doc/BRIEF.md
# Register File with Bitwise and Arithmetic Unit

This block holds the four 8-bit general-purpose registers of a small single-cycle 8-bit processor. It also executes the processor's bitwise and arithmetic instruction classes. Each instruction word has a 2-bit class in bits [7:6], a first operand index (`rs`) in bits [5:4], a second operand index (`rt`) in bits [3:2] and an operation code in bits [1:0]. When `instrValid` is high and the class is bitwise (00) or arithmetic (01), the block reads both operand registers, computes the result and writes it back at the same rising edge. The written value can be read from the next cycle onwards.

Two combinational read ports let neighbouring units see any register. Other units, such as the loads, the stack and the branch logic, put values into the registers through a single external write port. That port takes effect only in cycles when no bitwise or arithmetic instruction is being executed.

Top module: `regAluUnit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all four registers to 0.
- R2: `rdDataA` and `rdDataB` always show the register selected by `rdIdxA` and `rdIdxB`. A register written at an edge shows its new value right after that edge.
- R3: Bitwise op 00 (word `00xxxx00`) is a no-operation and changes no register.
- R4: Bitwise op 01 writes `rs AND rt` into register 3, and op 10 writes `rs OR rt` into register 3. No other register changes.
- R5: Bitwise op 11 writes the bitwise inverse of `rt` into register `rs`. Register 3 changes only when `rs` is 3.
- R6: Arithmetic op 00 writes `(rs + rt) mod 256` into register 3, and op 01 writes `(rs - rt) mod 256` into register 3. No carry or flag is kept.
- R7: Arithmetic op 10 writes `rs` shifted left by the value of `rt` into register 3, and op 11 writes `rs` shifted right the same way. Vacated bits fill with 0, and any shift amount of 8 or more gives 0.
- R8: While `instrValid` is low, the instruction word has no effect on any register.
- R9: A valid instruction of class 10 or 11 changes no register through this block. In such a cycle, or when `instrValid` is low, `extWrEn` high writes `extWrData` into register `extWrIdx`.
- R10: When a valid class 00 or class 01 instruction is present, the external write port is ignored in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instrValid | input | 1 | Instruction word is valid this cycle |
| instrWord | input | 8 | Instruction: class[7:6], rs[5:4], rt[3:2], op[1:0] |
| extWrEn | input | 1 | External register write request |
| extWrIdx | input | 2 | External write register index |
| extWrData | input | DATA_W | External write data |
| rdIdxA | input | 2 | Read port A register index |
| rdDataA | output | DATA_W | Read port A data |
| rdIdxB | input | 2 | Read port B register index |
| rdDataB | output | DATA_W | Read port B data |

## Verification
A wrong register state shows at the read ports right after the edge that caused it, because both ports read the registers without any delay. The bench checks every register through both ports after every instruction, so a fault is caught before the next instruction runs. A wrong destination shows up as a change in a register that should have held its value. A wrong operand order or a wrong shift fill shows up as a wrong value in register 3. The sweep covers all operations, all operand index pairs including equal indices, and shift amounts on both sides of 8, so each of these faults is reported in the first cycle after it happens.

// File: rtl/regAluPkg.sv
`timescale 1ns/1ps
package regAluPkg;
  localparam int FIELD_W    = 2;
  localparam int REG_NUM    = 1 << FIELD_W;
  localparam int INSTR_W    = 8;
  localparam logic [FIELD_W-1:0] RESULT_IDX = FIELD_W'(REG_NUM - 1);
  localparam logic [1:0] CLS_BIT   = 2'b00;
  localparam logic [1:0] CLS_ARITH = 2'b01;

  typedef enum logic [2:0] {
    ALU_PASS,
    ALU_AND,
    ALU_OR,
    ALU_INV,
    ALU_ADD,
    ALU_SUB,
    ALU_SHL,
    ALU_SHR
  } aluOpE;

  typedef struct packed {
    logic               wrEn;
    logic               wrFromExt;
    logic [FIELD_W-1:0] wrIdx;
    logic [FIELD_W-1:0] srcS;
    logic [FIELD_W-1:0] srcT;
    aluOpE              op;
  } ctrlStrobesT;
endpackage

// File: rtl/regAluCtrl.sv
`timescale 1ns/1ps
module regAluCtrl
  import regAluPkg::*;
(
  input  logic                instrValid,
  input  logic [INSTR_W-1:0]  instrWord,
  input  logic                extWrEn,
  input  logic [FIELD_W-1:0]  extWrIdx,
  output ctrlStrobesT         strobes
);
  logic [1:0]         clsBits;
  logic [FIELD_W-1:0] fieldS;
  logic [FIELD_W-1:0] fieldT;
  logic [1:0]         opBits;
  logic               aluCycle;
  aluOpE              opSel;

  assign clsBits  = instrWord[7:6];
  assign fieldS   = instrWord[5:4];
  assign fieldT   = instrWord[3:2];
  assign opBits   = instrWord[1:0];
  assign aluCycle = instrValid && ((clsBits == CLS_BIT) || (clsBits == CLS_ARITH));

  always_comb begin
    opSel = ALU_PASS;
    if (clsBits == CLS_BIT) begin
      unique case (opBits)
        2'b00:   opSel = ALU_PASS;
        2'b01:   opSel = ALU_AND;
        2'b10:   opSel = ALU_OR;
        default: opSel = ALU_INV;
      endcase
    end else begin
      unique case (opBits)
        2'b00:   opSel = ALU_ADD;
        2'b01:   opSel = ALU_SUB;
        2'b10:   opSel = ALU_SHL;
        default: opSel = ALU_SHR;
      endcase
    end
  end

  always_comb begin
    strobes.srcS      = fieldS;
    strobes.srcT      = fieldT;
    strobes.op        = opSel;
    strobes.wrFromExt = 1'b0;
    strobes.wrEn      = 1'b0;
    strobes.wrIdx     = RESULT_IDX;
    if (aluCycle) begin
      strobes.wrEn  = (opSel != ALU_PASS);
      strobes.wrIdx = (opSel == ALU_INV) ? fieldS : RESULT_IDX;
    end else if (extWrEn) begin
      strobes.wrEn      = 1'b1;
      strobes.wrFromExt = 1'b1;
      strobes.wrIdx     = extWrIdx;
    end
  end
endmodule

// File: rtl/regAluPath.sv
`timescale 1ns/1ps
module regAluPath
  import regAluPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrlStrobesT        strobes,
  input  logic [DATA_W-1:0]  extWrData,
  input  logic [FIELD_W-1:0] rdIdxA,
  output logic [DATA_W-1:0]  rdDataA,
  input  logic [FIELD_W-1:0] rdIdxB,
  output logic [DATA_W-1:0]  rdDataB
);
  localparam logic [31:0] SHIFT_LIM = 32'(DATA_W);

  logic [DATA_W-1:0] regBank [REG_NUM];
  logic [DATA_W-1:0] opS;
  logic [DATA_W-1:0] opT;
  logic [DATA_W-1:0] aluResult;
  logic [DATA_W-1:0] wrData;
  logic              shiftOut;

  assign opS      = regBank[strobes.srcS];
  assign opT      = regBank[strobes.srcT];
  assign shiftOut = (32'(opT) >= SHIFT_LIM);

  always_comb begin
    unique case (strobes.op)
      ALU_AND: aluResult = opS & opT;
      ALU_OR:  aluResult = opS | opT;
      ALU_INV: aluResult = ~opT;
      ALU_ADD: aluResult = opS + opT;
      ALU_SUB: aluResult = opS - opT;
      ALU_SHL: aluResult = shiftOut ? '0 : (opS << opT);
      ALU_SHR: aluResult = shiftOut ? '0 : (opS >> opT);
      default: aluResult = opS;
    endcase
  end

  assign wrData = strobes.wrFromExt ? extWrData : aluResult;

  for (genvar g = 0; g < REG_NUM; g++) begin : gReg
    logic hitWr;
    assign hitWr = strobes.wrEn && (strobes.wrIdx == FIELD_W'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        regBank[g] <= '0;
      end else if (hitWr) begin
        regBank[g] <= wrData;
      end
    end
  end

  assign rdDataA = regBank[rdIdxA];
  assign rdDataB = regBank[rdIdxB];
endmodule

// File: rtl/regAluUnit.sv
`timescale 1ns/1ps
module regAluUnit
  import regAluPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic               extWrEn,
  input  logic [FIELD_W-1:0] extWrIdx,
  input  logic [DATA_W-1:0]  extWrData,
  input  logic [FIELD_W-1:0] rdIdxA,
  output logic [DATA_W-1:0]  rdDataA,
  input  logic [FIELD_W-1:0] rdIdxB,
  output logic [DATA_W-1:0]  rdDataB
);
  ctrlStrobesT strobes;

  regAluCtrl u_ctrl (
    .instrValid (instrValid),
    .instrWord  (instrWord),
    .extWrEn    (extWrEn),
    .extWrIdx   (extWrIdx),
    .strobes    (strobes)
  );

  regAluPath #(.DATA_W(DATA_W)) u_path (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .extWrData (extWrData),
    .rdIdxA    (rdIdxA),
    .rdDataA   (rdDataA),
    .rdIdxB    (rdIdxB),
    .rdDataB   (rdDataB)
  );
endmodule

// File: rtl/regAluChecker.sv
`timescale 1ns/1ps
module regAluChecker
  import regAluPkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               instrValid,
  input logic [INSTR_W-1:0] instrWord,
  input logic               extWrEn,
  input logic [FIELD_W-1:0] extWrIdx,
  input logic [DATA_W-1:0]  extWrData,
  input logic [FIELD_W-1:0] rdIdxA,
  input logic [DATA_W-1:0]  rdDataA,
  input logic [FIELD_W-1:0] rdIdxB,
  input logic [DATA_W-1:0]  rdDataB
);
  logic [DATA_W-1:0]  shadow [REG_NUM];
  logic               rstPrev = 1'b0;
  logic               isNop;
  logic               modelWr;
  logic [FIELD_W-1:0] modelIdx;
  logic [DATA_W-1:0]  modelVal;
  logic [DATA_W-1:0]  valS;
  logic [DATA_W-1:0]  valT;
  int                 amount;

  assign isNop  = instrValid && (instrWord[7:6] == 2'b00) && (instrWord[1:0] == 2'b00);
  assign valS   = shadow[instrWord[5:4]];
  assign valT   = shadow[instrWord[3:2]];
  assign amount = int'(valT);

  always_comb begin
    modelWr  = 1'b0;
    modelIdx = RESULT_IDX;
    modelVal = '0;
    if (instrValid && !instrWord[7]) begin
      modelWr = !isNop;
      case ({instrWord[6], instrWord[1:0]})
        3'b001: modelVal = valS & valT;
        3'b010: modelVal = valS | valT;
        3'b011: begin modelVal = ~valT; modelIdx = instrWord[5:4]; end
        3'b100: modelVal = DATA_W'(int'(valS) + int'(valT));
        3'b101: modelVal = DATA_W'(int'(valS) - int'(valT));
        3'b110: modelVal = (amount >= DATA_W) ? '0 : DATA_W'(valS << amount);
        3'b111: modelVal = (amount >= DATA_W) ? '0 : DATA_W'(valS >> amount);
        default: modelVal = '0;
      endcase
    end else if (extWrEn) begin
      modelWr  = 1'b1;
      modelIdx = extWrIdx;
      modelVal = extWrData;
    end
  end

  always_ff @(posedge clk) begin
    rstPrev <= rst;
    for (int k = 0; k < REG_NUM; k++) begin
      if (rst) shadow[k] <= '0;
      else if (modelWr && (modelIdx == FIELD_W'(k))) shadow[k] <= modelVal;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rstPrev |-> (rdDataA == '0 && rdDataB == '0));  // R1

  AST_PORT_A_MODEL: assert property (@(posedge clk) disable iff (rst || rstPrev)
    rdDataA == shadow[rdIdxA]);  // R2

  AST_PORT_B_MODEL: assert property (@(posedge clk) disable iff (rst || rstPrev)
    rdDataB == shadow[rdIdxB]);  // R2

  AST_NOP_HOLD: assert property (@(posedge clk) disable iff (rst)
    isNop |=> ($stable(rdIdxA) -> $stable(rdDataA)));  // R3
endmodule

bind regAluUnit regAluChecker #(.DATA_W(DATA_W)) u_regAluChecker (
  .clk        (clk),
  .rst        (rst),
  .instrValid (instrValid),
  .instrWord  (instrWord),
  .extWrEn    (extWrEn),
  .extWrIdx   (extWrIdx),
  .extWrData  (extWrData),
  .rdIdxA     (rdIdxA),
  .rdDataA    (rdDataA),
  .rdIdxB     (rdIdxB),
  .rdDataB    (rdDataB)
);

// File: tb/test_regAluUnit.sv
`timescale 1ns/1ps
module test_regAluUnit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       instrValid = 1'b0;
  logic [7:0] instrWord = '0;
  logic       extWrEn = 1'b0;
  logic [1:0] extWrIdx = '0;
  logic [7:0] extWrData = '0;
  logic [1:0] rdIdxA = '0;
  logic [7:0] rdDataA;
  logic [1:0] rdIdxB = '0;
  logic [7:0] rdDataB;

  int checkCnt = 0;
  int failCnt = 0;
  int cycleCnt = 0;
  int model [4];

  always #10 clk = ~clk;

  regAluUnit #(.DATA_W(8)) i_regAluUnit (
    .clk(clk), .rst(rst), .instrValid(instrValid), .instrWord(instrWord),
    .extWrEn(extWrEn), .extWrIdx(extWrIdx), .extWrData(extWrData),
    .rdIdxA(rdIdxA), .rdDataA(rdDataA), .rdIdxB(rdIdxB), .rdDataB(rdDataB)
  );

  always @(posedge clk) begin
    cycleCnt <= cycleCnt + 1;
    if (cycleCnt > 150000) begin
      failCnt = failCnt + 1;
      $display("FAIL watchdog: run did not end, actual %0d cycles expected fewer", cycleCnt);
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  task automatic check(input int actual, input int expected, input string tag);
    checkCnt++;
    if (actual != expected) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", tag, actual, expected);
    end
  endtask

  function automatic string tagFor(input logic [7:0] w);
    if (w[7:6] == 2'b00) begin
      if (w[1:0] == 2'b00) return "R3";
      if (w[1:0] == 2'b11) return "R5";
      return "R4";
    end
    if (w[1] == 1'b0) return "R6";
    return "R7";
  endfunction

  function automatic void applyModel(input logic [7:0] w, input bit v,
                                     input bit eEn, input int eIdx, input int eData);
    int a, b, s, t, r;
    s = int'(w[5:4]);
    t = int'(w[3:2]);
    a = model[s];
    b = model[t];
    if (v && w[7:6] == 2'b00) begin
      case (w[1:0])
        2'b01: model[3] = a & b;
        2'b10: model[3] = a | b;
        2'b11: model[s] = 255 - b;
        default: ;
      endcase
    end else if (v && w[7:6] == 2'b01) begin
      case (w[1:0])
        2'b00: r = (a + b) % 256;
        2'b01: r = (a - b + 256) % 256;
        2'b10: r = (b >= 8) ? 0 : ((a * (1 << b)) % 256);
        default: r = (b >= 8) ? 0 : (a / (1 << b));
      endcase
      model[3] = r;
    end else if (eEn) begin
      model[eIdx] = eData;
    end
  endfunction

  task automatic drive(input logic [7:0] w, input bit v, input bit eEn,
                       input int eIdx, input int eData);
    @(negedge clk);
    instrWord  = w;
    instrValid = v;
    extWrEn    = eEn;
    extWrIdx   = 2'(eIdx);
    extWrData  = 8'(eData);
    applyModel(w, v, eEn, eIdx, eData);
    @(negedge clk);
    instrValid = 1'b0;
    extWrEn    = 1'b0;
  endtask

  task automatic setReg(input int idx, input int val);
    drive(8'hC0, 1'b0, 1'b1, idx, val);
  endtask

  task automatic checkAll(input string tag);
    for (int r = 0; r < 4; r++) begin
      rdIdxA = 2'(r);
      rdIdxB = 2'(3 - r);
      #1;
      check(int'(rdDataA), model[r], tag);
      check(int'(rdDataB), model[3 - r], "R2");
    end
  endtask

  initial begin
    int pa [8] = '{0, 1, 255, 8'h5A, 200, 7, 8'h80, 8'h81};
    int pb [8] = '{0, 1, 1, 8'hC3, 100, 3, 8, 9};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int r = 0; r < 4; r++) model[r] = 0;
    checkAll("R1");
    for (int r = 0; r < 4; r++) setReg(r, 8'h11 * (r + 1));
    checkAll("R9");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int r = 0; r < 4; r++) model[r] = 0;
    checkAll("R1");

    for (int op = 0; op < 8; op++)
      for (int s = 0; s < 4; s++)
        for (int t = 0; t < 4; t++)
          for (int p = 0; p < 8; p++) begin
            logic [7:0] w;
            w = {2'(op >> 2), 2'(s), 2'(t), 2'(op & 3)};
            for (int r = 0; r < 4; r++) setReg(r, 8'h33 + 8'h17 * r);
            setReg(s, pa[p]);
            setReg(t, pb[p]);
            drive(w, 1'b1, 1'b0, 0, 0);
            checkAll(tagFor(w));
          end

    for (int amt = 0; amt < 16; amt++) begin
      setReg(0, 8'hB5); setReg(1, amt);
      drive(8'b01_00_01_10, 1'b1, 1'b0, 0, 0);
      checkAll("R7");
      drive(8'b01_00_01_11, 1'b1, 1'b0, 0, 0);
      checkAll("R7");
    end

    for (int k = 0; k < 8; k++) begin
      setReg(0, 10 + k); setReg(1, 3);
      drive(8'b01_00_01_00, 1'b0, 1'b0, 0, 0);
      checkAll("R8");
    end

    for (int k = 0; k < 64; k++) begin
      logic [7:0] w;
      w = 8'h80 + 8'(k * 2);
      drive(w, 1'b1, 1'b0, 0, 0);
      checkAll("R9");
      drive(w, 1'b1, 1'b1, k % 4, (k * 37) % 256);
      checkAll("R9");
    end

    for (int k = 0; k < 32; k++) begin
      logic [7:0] w;
      w = {1'b0, 1'(k % 2), 2'(k / 8), 2'(k / 2), 2'(k)};
      setReg(0, 40 + k); setReg(1, 5); setReg(2, 9); setReg(3, 200);
      drive(w, 1'b1, 1'b1, k % 4, 8'hEE);
      checkAll("R10");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule